// File: doc/BRIEF.md
# Instruction Fetch Translation Buffer

This block is a four-slot translation cache on the instruction fetch path. It sits in front of a larger unified translation table. A fetch request carries a virtual address, an address-space identifier and two mode bits: privileged execution, and single-virtual-space. The block compares the request against all four slots at once. Each slot supports four page sizes and can be marked as shared across address spaces. On a single match, the block returns the physical address and refreshes a 6-bit least-recently-used word.

When no slot matches, the block sends one request to the unified table and waits for its answer. A good answer is written into the slot that the LRU word names as victim, and the lookup runs again, which then hits. A miss or multi-hit answer from the unified table goes back to the requester unchanged. Two or more matching local slots give a multi-hit status. A flush input invalidates every slot.

Top module: `fetch_tlb`

## Requirements
- R1: After reset, resp_valid and utlb_req_valid are 0, req_ready is 1, lru_state is 0 and no slot is valid.
- R2: A slot matches when it is valid and the virtual address agrees with its page number above the page boundary. The page size codes are 0 = 1 KB, 1 = 4 KB, 2 = 64 KB and 3 = 1 MB. On a single match the status is 0 (ok), and resp_pa takes the slot's physical page bits above the page boundary and the request's address bits below it. No unified-table request is made.
- R3: The identifier comparison is skipped when the slot is shared, or when req_priv and req_sv are both 1. Otherwise the slot's identifier must equal req_asid.
- R4: A single match on slot e sets lru_state to (lru_state AND keep[e]) OR set[e]. keep = 0x07, 0x39, 0x3E, 0x3F and set = 0x00, 0x20, 0x14, 0x0B for e = 0, 1, 2, 3.
- R5: When no slot matches, exactly one utlb_req_valid pulse is issued carrying the request address. req_ready stays 0 until the response, so only one refill is in flight at a time.
- R6: A good unified answer (status 0) goes into the victim slot e, defined by (lru_state AND (key[e] OR set[e])) == key[e] with key[e] = NOT keep[e] AND 0x3F. The lowest such e wins, and a word that names no victim selects slot 0. The lookup then repeats and answers as in R2 and R4.
- R7: A unified answer with status 1 (miss) or 2 (multi-hit) is returned unchanged as resp_status. No slot changes and lru_state is unchanged.
- R8: Two or more matching slots give status 2, with lru_state unchanged and no unified-table request.
- R9: A flush pulse invalidates all four slots from the next cycle, so a previously hitting address goes to the unified table again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all slots |
| req_valid | input | 1 | Fetch lookup request |
| req_ready | output | 1 | Block idle and accepting a request |
| req_va | input | 32 | Fetch virtual address |
| req_asid | input | 8 | Current address-space identifier |
| req_priv | input | 1 | Privileged execution mode |
| req_sv | input | 1 | Single-virtual-space mode |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 2 | 0 ok, 1 miss, 2 multi-hit |
| resp_pa | output | 32 | Translated physical address |
| lru_state | output | 6 | Replacement order word |
| utlb_req_valid | output | 1 | Request to unified table |
| utlb_req_va | output | 32 | Address sent to unified table |
| utlb_resp_valid | input | 1 | Unified table answer strobe |
| utlb_resp_status | input | 2 | Unified answer status, same encoding |
| utlb_resp_vpn | input | 22 | Returned virtual page number |
| utlb_resp_asid | input | 8 | Returned identifier |
| utlb_resp_ppn | input | 22 | Returned physical page number |
| utlb_resp_size | input | 2 | Returned page size code |
| utlb_resp_shared | input | 1 | Returned shared flag |

## Verification
The bench builds the block with its package defaults: 32-bit addresses, 1 KB base pages, 8-bit identifiers and four slots. With those values, an eight-entry unified table model can hold overlapping pages of every size, shared pages and per-identifier pages. That setup reaches refills into each victim position, unified miss and multi-hit answers, and local multi-hits built from a large page and a small page loaded under different identifiers. Random fetches with random answer delays and occasional flushes are compared against a reference model of the slots and the LRU word.

// File: rtl/fetch_tlb_pkg.sv
package fetch_tlb_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 10;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int PPN_W      = 22;
  localparam int PA_W       = PPN_W + PAGE_SHIFT;
  localparam int ASID_W     = 8;
  localparam int N_ENT      = 4;
  localparam int IDX_W      = $clog2(N_ENT);
  localparam int CNT_W      = $clog2(N_ENT + 1);
  localparam int LRU_W      = 6;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [1:0]        size;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_MISS  = 2'd1,
    ST_MULTI = 2'd2
  } fetch_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOKUP, S_REFILL_REQ, S_REFILL_WAIT, S_RETRY
  } fsm_e;

  // Page-number compare mask; larger pages drop more low page bits.
  function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    case (sz)
      2'd1:    m = m << 2;
      2'd2:    m = m << 6;
      2'd3:    m = m << 10;
      default: m = m;
    endcase
    return m;
  endfunction

  function automatic logic [LRU_W-1:0] lru_keep(input int e);
    case (e)
      0:       return 6'h07;
      1:       return 6'h39;
      2:       return 6'h3E;
      default: return 6'h3F;
    endcase
  endfunction

  function automatic logic [LRU_W-1:0] lru_set(input int e);
    case (e)
      0:       return 6'h00;
      1:       return 6'h20;
      2:       return 6'h14;
      default: return 6'h0B;
    endcase
  endfunction

  function automatic logic [LRU_W-1:0] lru_key(input int e);
    return ~lru_keep(e) & 6'h3F;
  endfunction
endpackage

// File: rtl/fetch_tlb_match.sv
module fetch_tlb_match
  import fetch_tlb_pkg::*;
(
  input  tlb_entry_t [N_ENT-1:0] ent,
  input  logic [VA_W-1:0]        va,
  input  logic [ASID_W-1:0]      asid,
  input  logic                   priv,
  input  logic                   sv,
  output logic [N_ENT-1:0]       hit,
  output logic [PA_W-1:0]        pa
);
  logic [PA_W-1:0] pa_e [N_ENT];
  logic [VPN_W-1:0] va_pg;

  assign va_pg = va[VA_W-1:PAGE_SHIFT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    logic [VPN_W-1:0] msk;
    logic             pg_eq, id_ok;
    assign msk     = size_mask(ent[i].size);
    assign pg_eq   = ((ent[i].vpn ^ va_pg) & msk) == '0;
    assign id_ok   = ent[i].shared | (priv & sv) | (ent[i].asid == asid);
    assign hit[i]  = ent[i].valid & pg_eq & id_ok;
    assign pa_e[i] = {(ent[i].ppn & msk) | (va_pg & ~msk), va[PAGE_SHIFT-1:0]};
  end

  always_comb begin
    pa = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit[i]) pa = pa | pa_e[i];
    end
  end
endmodule

// File: rtl/fetch_tlb_lru.sv
module fetch_tlb_lru
  import fetch_tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  output logic [LRU_W-1:0] lru_q,
  output logic [IDX_W-1:0] victim,
  output logic             victim_ok
);
  logic [LRU_W-1:0] lru_d;

  always_comb begin
    lru_d = lru_q;
    if (upd_en) lru_d = (lru_q & lru_keep(int'(upd_idx))) | lru_set(int'(upd_idx));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (upd_en) lru_q <= lru_d;
  end

  // Lowest matching slot wins; no match falls back to slot 0.
  always_comb begin
    victim    = '0;
    victim_ok = 1'b0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if ((lru_q & (lru_key(e) | lru_set(e))) == lru_key(e)) begin
        victim    = IDX_W'(e);
        victim_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fetch_tlb.sv
module fetch_tlb
  import fetch_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_priv,
  input  logic              req_sv,
  output logic              resp_valid,
  output logic [1:0]        resp_status,
  output logic [PA_W-1:0]   resp_pa,
  output logic [LRU_W-1:0]  lru_state,
  output logic              utlb_req_valid,
  output logic [VA_W-1:0]   utlb_req_va,
  input  logic              utlb_resp_valid,
  input  logic [1:0]        utlb_resp_status,
  input  logic [VPN_W-1:0]  utlb_resp_vpn,
  input  logic [ASID_W-1:0] utlb_resp_asid,
  input  logic [PPN_W-1:0]  utlb_resp_ppn,
  input  logic [1:0]        utlb_resp_size,
  input  logic              utlb_resp_shared
);
  fsm_e                   state_q, state_d;
  logic [VA_W-1:0]        va_q;
  logic [ASID_W-1:0]      asid_q;
  logic                   priv_q, sv_q;
  tlb_entry_t [N_ENT-1:0] ent_q;
  tlb_entry_t             refill_ent;
  logic [N_ENT-1:0]       hit, valid_vec;
  logic [PA_W-1:0]        hit_pa;
  logic [CNT_W-1:0]       hit_cnt;
  logic [IDX_W-1:0]       hit_idx, victim;
  logic                   victim_ok, in_lookup, cap_en, refill_en, lru_upd;
  logic                   resp_v_d, resp_v_q;
  fetch_status_e          resp_st_d, resp_st_q;
  logic [PA_W-1:0]        resp_pa_d, resp_pa_q;

  for (genvar i = 0; i < N_ENT; i++) begin : g_vld
    assign valid_vec[i] = ent_q[i].valid;
  end

  assign refill_ent = '{valid: 1'b1, shared: utlb_resp_shared, size: utlb_resp_size,
                        asid: utlb_resp_asid, vpn: utlb_resp_vpn, ppn: utlb_resp_ppn};

  fetch_tlb_match u_match (
    .ent(ent_q), .va(va_q), .asid(asid_q), .priv(priv_q), .sv(sv_q),
    .hit(hit), .pa(hit_pa)
  );

  fetch_tlb_lru u_lru (
    .clk(clk), .rst_n(rst_n), .upd_en(lru_upd), .upd_idx(hit_idx),
    .lru_q(lru_state), .victim(victim), .victim_ok(victim_ok)
  );

  assign hit_cnt   = CNT_W'($countones(hit));
  assign in_lookup = (state_q == S_LOOKUP) || (state_q == S_RETRY);
  assign lru_upd   = in_lookup && (hit_cnt == CNT_W'(1));

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IDX_W'(i);
    end
  end

  // Next-state and response selection
  always_comb begin
    state_d   = state_q;
    cap_en    = 1'b0;
    refill_en = 1'b0;
    resp_v_d  = 1'b0;
    resp_st_d = ST_OK;
    resp_pa_d = hit_pa;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = S_LOOKUP;
        end
      end
      S_LOOKUP, S_RETRY: begin
        if (hit_cnt == '0 && state_q == S_LOOKUP) begin
          state_d = S_REFILL_REQ;
        end else begin
          state_d   = S_IDLE;
          resp_v_d  = 1'b1;
          resp_st_d = (hit_cnt == '0) ? ST_MISS :
                      (hit_cnt == CNT_W'(1)) ? ST_OK : ST_MULTI;
        end
      end
      S_REFILL_REQ: state_d = S_REFILL_WAIT;
      S_REFILL_WAIT: begin
        if (utlb_resp_valid) begin
          if (utlb_resp_status == ST_OK) begin
            refill_en = 1'b1;
            state_d   = S_RETRY;
          end else begin
            resp_v_d  = 1'b1;
            resp_st_d = fetch_status_e'(utlb_resp_status);
            state_d   = S_IDLE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      resp_v_q  <= 1'b0;
      resp_st_q <= ST_OK;
      resp_pa_q <= '0;
    end else begin
      state_q  <= state_d;
      resp_v_q <= resp_v_d;
      if (resp_v_d) begin
        resp_st_q <= resp_st_d;
        resp_pa_q <= resp_pa_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      asid_q <= '0;
      priv_q <= 1'b0;
      sv_q   <= 1'b0;
    end else if (cap_en) begin
      va_q   <= req_va;
      asid_q <= req_asid;
      priv_q <= req_priv;
      sv_q   <= req_sv;
    end
  end

  // Slot storage: flush has priority over a refill write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (flush) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i].valid <= 1'b0;
    end else if (refill_en) begin
      ent_q[victim] <= refill_ent;
    end
  end

  assign req_ready      = (state_q == S_IDLE);
  assign utlb_req_valid = (state_q == S_REFILL_REQ);
  assign utlb_req_va    = va_q;
  assign resp_valid     = resp_v_q;
  assign resp_status    = resp_st_q;
  assign resp_pa        = resp_pa_q;
endmodule

// File: rtl/fetch_tlb_sva.sv
module fetch_tlb_sva
  import fetch_tlb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             req_ready,
  input logic             resp_valid,
  input logic [1:0]       resp_status,
  input logic [LRU_W-1:0] lru_state,
  input logic             utlb_req_valid,
  input logic             utlb_resp_valid,
  input logic [1:0]       utlb_resp_status,
  input fsm_e             state_q,
  input logic [N_ENT-1:0] valid_vec,
  input logic             victim_ok,
  input logic             lru_upd,
  input logic [IDX_W-1:0] hit_idx
);
  AST_SINGLE_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_req_valid |=> !utlb_req_valid); // R5
  AST_BUSY_DURING_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_req_valid |-> !req_ready); // R5
  AST_FLUSH_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0)); // R9
  AST_VICTIM_DECODES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_REFILL_WAIT) |-> victim_ok); // R6
  AST_ERR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_REFILL_WAIT && utlb_resp_valid && utlb_resp_status != ST_OK)
    |=> (resp_valid && resp_status == $past(utlb_resp_status))); // R7
  AST_MULTI_KEEPS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == ST_MULTI) |-> $stable(lru_state)); // R8
  AST_HIT_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    lru_upd |=> ((lru_state & (lru_key(int'($past(hit_idx))) | lru_set(int'($past(hit_idx)))))
                 == lru_set(int'($past(hit_idx))))); // R4
endmodule

bind fetch_tlb fetch_tlb_sva chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_status(resp_status), .lru_state(lru_state),
  .utlb_req_valid(utlb_req_valid), .utlb_resp_valid(utlb_resp_valid),
  .utlb_resp_status(utlb_resp_status), .state_q(state_q), .valid_vec(valid_vec),
  .victim_ok(victim_ok), .lru_upd(lru_upd), .hit_idx(hit_idx)
);

// File: tb/fetch_tlb_tb_top.sv
module fetch_tlb_tb_top;
  import fetch_tlb_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk, rst_n, flush, req_valid, req_ready, req_priv, req_sv;
  logic [31:0]       req_va, resp_pa, utlb_req_va;
  logic [7:0]        req_asid, utlb_resp_asid;
  logic              resp_valid, utlb_req_valid, utlb_resp_valid, utlb_resp_shared;
  logic [1:0]        resp_status, utlb_resp_status, utlb_resp_size;
  logic [5:0]        lru_state;
  logic [21:0]       utlb_resp_vpn, utlb_resp_ppn;

  int checks = 0, errors = 0;
  tlb_entry_t m_ent [4];
  logic [5:0] m_lru;
  localparam logic [5:0] AM [4] = '{6'h07, 6'h39, 6'h3E, 6'h3F};
  localparam logic [5:0] OM [4] = '{6'h00, 6'h20, 6'h14, 6'h0B};

  fetch_tlb dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic tlb_entry_t mk(input logic [31:0] va, input logic [31:0] pa,
                                    input logic [1:0] sz, input logic [7:0] id, input bit sh);
    tlb_entry_t t;
    t.valid = 1'b1; t.shared = sh; t.size = sz; t.asid = id;
    t.vpn = va[31:10]; t.ppn = pa[31:10];
    return t;
  endfunction

  // Unified table held by the responder
  function automatic tlb_entry_t ut_entry(input int i);
    case (i)
      0: return mk(32'h0040_0000, 32'h0C00_0000, 2'd3, 8'd1, 1'b0);
      1: return mk(32'h0050_0000, 32'h0A01_0000, 2'd2, 8'd2, 1'b0);
      2: return mk(32'h0050_0000, 32'h0A02_0000, 2'd2, 8'd3, 1'b0);
      3: return mk(32'h0060_1000, 32'h0B00_3000, 2'd1, 8'd0, 1'b1);
      4: return mk(32'h0060_0400, 32'h0B10_0800, 2'd0, 8'd1, 1'b0);
      5: return mk(32'h0070_0000, 32'h0D00_0000, 2'd3, 8'd5, 1'b1);
      6: return mk(32'h0070_8000, 32'h0D80_0000, 2'd2, 8'd5, 1'b1);
      default: return mk(32'h0060_0000, 32'h0E00_0000, 2'd3, 8'd6, 1'b0);
    endcase
  endfunction

  function automatic logic [31:0] pmask(input logic [1:0] sz);
    case (sz)
      2'd0: return 32'hFFFF_FC00;
      2'd1: return 32'hFFFF_F000;
      2'd2: return 32'hFFFF_0000;
      default: return 32'hFFF0_0000;
    endcase
  endfunction

  function automatic bit m_match(input tlb_entry_t t, input logic [31:0] va,
                                 input logic [7:0] id, input bit pv, input bit s);
    logic [31:0] m;
    m = pmask(t.size);
    if (!t.valid) return 0;
    if ((({t.vpn, 10'd0} ^ va) & m) != 0) return 0;
    return t.shared || (pv && s) || (t.asid == id);
  endfunction

  function automatic logic [31:0] m_pa(input tlb_entry_t t, input logic [31:0] va);
    return ({t.ppn, 10'd0} & pmask(t.size)) | (va & ~pmask(t.size));
  endfunction

  function automatic int m_victim(input logic [5:0] l);
    for (int e = 0; e < 4; e++)
      if ((l & ((~AM[e] & 6'h3F) | OM[e])) == (~AM[e] & 6'h3F)) return e;
    return 0;
  endfunction

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int e = 0; e < 4; e++) m_ent[e].valid = 1'b0;
  endtask

  task automatic fetch(input logic [31:0] va, input logic [7:0] id, input bit pv,
                       input bit s, input string tag);
    int n = 0, idx = 0, un = 0, uidx = 0, reqs = 0, cyc = 0, v;
    logic [1:0] est = ST_OK;
    logic [31:0] epa = 0;
    int ereq = 0;
    logic [5:0] elru = m_lru;
    for (int e = 0; e < 4; e++) if (m_match(m_ent[e], va, id, pv, s)) begin n++; idx = e; end
    for (int u = 0; u < 8; u++) if (m_match(ut_entry(u), va, id, pv, s)) begin un++; uidx = u; end
    if (n == 1) begin
      epa = m_pa(m_ent[idx], va); elru = (m_lru & AM[idx]) | OM[idx];
    end else if (n > 1) begin
      est = ST_MULTI;
    end else begin
      ereq = 1;
      if (un == 1) begin
        v = m_victim(m_lru);
        m_ent[v] = ut_entry(uidx);
        epa = m_pa(m_ent[v], va); elru = (m_lru & AM[v]) | OM[v];
      end else est = (un == 0) ? ST_MISS : ST_MULTI;
    end
    m_lru = elru;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_asid = id; req_priv = pv; req_sv = s;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid && cyc < 64) begin
      if (utlb_req_valid) begin
        reqs++;
        chk(utlb_req_va == va, "R5", "refill address", utlb_req_va, va);
        chk(!req_ready, "R5", "ready during refill", 32'(req_ready), 0);
        repeat (1 + $urandom % 3) @(negedge clk);
        {utlb_resp_shared, utlb_resp_size, utlb_resp_asid, utlb_resp_vpn, utlb_resp_ppn} =
          {ut_entry(uidx).shared, ut_entry(uidx).size, ut_entry(uidx).asid,
           ut_entry(uidx).vpn, ut_entry(uidx).ppn};
        utlb_resp_status = (un == 0) ? ST_MISS : (un > 1) ? ST_MULTI : ST_OK;
        utlb_resp_valid = 1'b1;
        @(negedge clk);
        utlb_resp_valid = 1'b0;
      end else @(negedge clk);
      cyc++;
    end
    chk(resp_valid, tag, "response strobe", 32'(resp_valid), 1);
    chk(resp_status == est, tag, "status", 32'(resp_status), 32'(est));
    if (est == ST_OK) chk(resp_pa == epa, tag, "physical address", resp_pa, epa);
    chk(reqs == ereq, tag, "unified requests", reqs, ereq);
    chk(lru_state == elru, tag, "lru word", 32'(lru_state), 32'(elru));
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] bases [5];
    bases = '{32'h0040_0000, 32'h0050_0000, 32'h0060_0000, 32'h0070_0000, 32'h0090_0000};
    void'($urandom(32'd4711));
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_va = '0; req_asid = '0;
    req_priv = 1'b0; req_sv = 1'b0; utlb_resp_valid = 1'b0; utlb_resp_status = '0;
    utlb_resp_vpn = '0; utlb_resp_ppn = '0; utlb_resp_asid = '0; utlb_resp_size = '0;
    utlb_resp_shared = 1'b0;
    for (int e = 0; e < 4; e++) m_ent[e] = '0;
    m_lru = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!resp_valid, "R1", "reset resp_valid", 32'(resp_valid), 0);
    chk(!utlb_req_valid, "R1", "reset refill request", 32'(utlb_req_valid), 0);
    chk(req_ready, "R1", "reset ready", 32'(req_ready), 1);
    chk(lru_state == 0, "R1", "reset lru", 32'(lru_state), 0);
    fetch(32'h0040_0123, 8'd1, 0, 0, "R1");   // empty slots must miss
    chk(resp_pa == 32'h0C00_0123 && lru_state == 6'h0B, "R6", "refill into slot 3",
        {resp_pa[27:0], 4'(lru_state)}, {28'hC000123, 4'hB});
    fetch(32'h0040_0FFC, 8'd1, 0, 0, "R2");   // 1 MB page hit
    fetch(32'h0040_0200, 8'd2, 0, 0, "R3");   // identifier mismatch, unified miss
    fetch(32'h0040_0200, 8'd2, 1, 1, "R3");   // identifier ignored
    fetch(32'h0050_ABCD, 8'd2, 0, 0, "R2");   // 64 KB page
    fetch(32'h0050_ABCD, 8'd3, 0, 0, "R6");
    fetch(32'h0060_1ABC, 8'd9, 0, 0, "R3");   // shared 4 KB page
    fetch(32'h0070_8010, 8'd5, 0, 0, "R7");   // unified multi-hit
    fetch(32'h0090_0000, 8'd5, 0, 0, "R7");   // unified miss
    fetch(32'h0068_0000, 8'd6, 0, 0, "R4");
    fetch(32'h0060_0400, 8'd1, 0, 0, "R4");
    fetch(32'h0060_0404, 8'd1, 1, 1, "R8");   // two slots match
    do_flush();
    fetch(32'h0068_0000, 8'd6, 0, 0, "R9");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] va;
      logic [7:0] id;
      va = bases[$urandom % 5] | ($urandom & 32'h000F_FFFC);
      id = 8'($urandom % 10);
      if ($urandom % 20 == 0) do_flush();
      fetch(va, id, 1'($urandom), 1'($urandom), "R6");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule